// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block sits beside a small processor core and decides which interrupt, if any, the core should take next. Up to six request lines come in. Each line has its own enable bit, a single global enable gates all of them, and a per-source level bit places each line in either the high or the low priority level. Among the requests that may be taken, a high-level request always wins. Within one level a fixed source order breaks ties.

A request is taken only when the core signals that the current instruction has finished. When a request is taken, the block raises a one-cycle accept strobe and presents the service-routine address of the winning source, and it records which level is now in service. While a low-level routine runs, only high-level requests can break in. While a high-level routine runs, nothing can. A return strobe from the core closes the innermost open level. The stack, the program counter and instruction fetch stay in the core.

Top module: `irq_arb2`

## Requirements
- R1: During and after a synchronous active-high reset, `accept`, `vec_addr`, `svc_hi` and `svc_lo` are all zero until the first acceptance.
- R2: A request line n takes part in arbitration only when `src_en[n]` and `glb_en` are both 1. Otherwise it causes no acceptance and no change of any output.
- R3: When eligible requests exist in both levels, the one whose `src_lvl` bit is 1 (high level) is taken, whatever its source index.
- R4: Among eligible requests of one level, the lowest bit index wins. The index order is 0 first, then 1, 2, 3, 4, 5, which is external 0, timer 0, external 1, timer 1, serial, timer 2.
- R5: `accept` is high for exactly the cycle after a clock edge at which `insn_done` was 1 and a request could be taken. With `insn_done` low, no acceptance happens.
- R6: In the cycle `accept` is high, `vec_addr` equals 0x0003 + 8·n for winning index n (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B). It holds that value until the next acceptance.
- R7: Taking a request sets `svc_hi` or `svc_lo`, according to the winner's level, in the same cycle as `accept`. While that flag is set, further requests of that level are not taken.
- R8: With only `svc_lo` set, a high-level request is still taken (nesting). With `svc_hi` set, no request is taken.
- R9: A clock edge with `reti` high clears `svc_hi` if it is set, and otherwise clears `svc_lo`. No request is taken at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NSRC | Request lines, bit n is source n |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | NSRC | Per-source enable |
| src_lvl | input | NSRC | Per-source level, 1 is high |
| insn_done | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt strobe |
| accept | output | 1 | One-cycle acceptance strobe |
| vec_addr | output | VEC_W | Service-routine address of the last accepted source |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |

## Verification
A wrong in-service flag shows up on the flag ports in the very next cycle. Its effect on arbitration shows up later: a same-level request that is wrongly accepted, or a preempting request that is wrongly refused, appears at `accept` at the first edge where a qualifying request meets `insn_done`. A wrong winner selection appears at once in `vec_addr` alongside the strobe. The bench compares every output with a behavioural model on every cycle, so any divergence is reported in the cycle it becomes visible.

// File: rtl/irq_arb2_pkg.sv
package irq_arb2_pkg;
  localparam int unsigned LEVELS = 2;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} irq_lvl_e;
endpackage

// File: rtl/irq_pick.sv
// Lowest-index-first selection over one level's eligible requests.
module irq_pick #(
  parameter int unsigned N  = 6,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_svc.sv
// In-service level tracking: one flag per level, innermost closed first.
module irq_svc (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else if (reti) begin
      if (svc_hi) svc_hi <= 1'b0;
      else        svc_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) svc_hi <= 1'b1;
      else         svc_lo <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_arb2.sv
module irq_arb2
  import irq_arb2_pkg::*;
#(
  parameter int unsigned NSRC       = 6,
  parameter int unsigned VEC_W      = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_lvl,
  input  logic             insn_done,
  input  logic             reti,
  output logic             accept,
  output logic [VEC_W-1:0] vec_addr,
  output logic             svc_hi,
  output logic             svc_lo
);
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] lvl_req [LEVELS];
  logic [LEVELS-1:0] lvl_any;
  logic [IW-1:0]   lvl_idx [LEVELS];
  logic            hi_ok, lo_ok, take, take_hi;
  logic [IW-1:0]   win_idx;

  assign elig           = irq_req & src_en & {NSRC{glb_en}};
  assign lvl_req[LVL_HI] = elig & src_lvl;
  assign lvl_req[LVL_LO] = elig & ~src_lvl;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    irq_pick #(.N(NSRC)) u_pick (
      .req (lvl_req[g]),
      .any (lvl_any[g]),
      .idx (lvl_idx[g])
    );
  end

  // High level is blocked only by itself; low level by either flag.
  assign hi_ok   = lvl_any[LVL_HI] & ~svc_hi;
  assign lo_ok   = lvl_any[LVL_LO] & ~svc_hi & ~svc_lo;
  assign take    = insn_done & ~reti & (hi_ok | lo_ok);
  assign take_hi = hi_ok;
  assign win_idx = hi_ok ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];

  irq_svc u_svc (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (take_hi),
    .reti    (reti),
    .svc_hi  (svc_hi),
    .svc_lo  (svc_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept   <= 1'b0;
      vec_addr <= '0;
    end else begin
      accept <= take;
      if (take)
        vec_addr <= VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(win_idx);
    end
  end
endmodule

// File: rtl/irq_arb2_chk.sv
module irq_arb2_chk #(
  parameter int unsigned VEC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_done,
  input logic             reti,
  input logic             accept,
  input logic [VEC_W-1:0] vec_addr,
  input logic             svc_hi,
  input logic             svc_lo
);
  // R5
  acc_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(insn_done));
  // R9
  acc_not_on_reti_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> !$past(reti));
  // R8
  hi_blocks_all_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> !$past(svc_hi));
  // R7
  lo_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(svc_lo) |-> accept);
  // R7
  hi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(svc_hi) |-> accept);
  // R9
  reti_hi_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reti) && $past(svc_hi)) |-> (!svc_hi && svc_lo == $past(svc_lo)));
  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vec_addr) |-> accept);
endmodule

bind irq_arb2 irq_arb2_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .insn_done(insn_done), .reti(reti),
  .accept(accept), .vec_addr(vec_addr), .svc_hi(svc_hi), .svc_lo(svc_lo)
);

// File: tb/irq_arb2_bench.sv
`timescale 1ns/1ps
module irq_arb2_bench;
  localparam int NS = 6;
  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] irq_req = '0, src_en = '0, src_lvl = '0;
  logic glb_en = 1'b0, insn_done = 1'b0, reti = 1'b0;
  logic accept, svc_hi, svc_lo;
  logic [15:0] vec_addr;

  irq_arb2 u_irq_arb2 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .glb_en(glb_en),
    .src_en(src_en), .src_lvl(src_lvl), .insn_done(insn_done),
    .reti(reti), .accept(accept), .vec_addr(vec_addr),
    .svc_hi(svc_hi), .svc_lo(svc_lo)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  // Behavioural reference model
  bit m_acc, m_hi, m_lo;
  int m_vec;
  always @(posedge clk) begin
    int pick;
    bit pick_hi;
    if (rst) begin
      m_acc = 0; m_hi = 0; m_lo = 0; m_vec = 0;
    end else begin
      pick = -1; pick_hi = 0;
      if (!m_hi)
        for (int i = 0; i < NS; i++)
          if (pick < 0 && irq_req[i] && src_en[i] && glb_en && src_lvl[i]) begin
            pick = i; pick_hi = 1;
          end
      if (pick < 0 && !m_hi && !m_lo)
        for (int i = 0; i < NS; i++)
          if (pick < 0 && irq_req[i] && src_en[i] && glb_en && !src_lvl[i])
            pick = i;
      m_acc = 0;
      if (reti) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end else if (insn_done && pick >= 0) begin
        m_acc = 1;
        m_vec = 3 + 8 * pick;
        if (pick_hi) m_hi = 1; else m_lo = 1;
      end
    end
  end

  // Cycle compare, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      total++;
      if (accept !== m_acc || vec_addr !== 16'(m_vec) ||
          svc_hi !== m_hi || svc_lo !== m_lo) begin
        bad++;
        $display("FAIL %s: got acc=%0b vec=%h hi=%0b lo=%0b exp acc=%0b vec=%h hi=%0b lo=%0b",
                 cur_req, accept, vec_addr, svc_hi, svc_lo, m_acc, 16'(m_vec), m_hi, m_lo);
      end
    end
  end

  task automatic chk(input string r, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  // Drive at a falling edge; outputs are read at the next falling edge.
  task automatic step(input logic [NS-1:0] rq, input logic dn, input logic rt);
    irq_req = rq; insn_done = dn; reti = rt;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", {accept, svc_hi, svc_lo}, 0);
    chk("R1", vec_addr, 0);
    rst = 1'b0;
    step('0, 0, 0);
    chk("R1", {accept, svc_hi, svc_lo}, 0);

    // R2: enables gate requests
    cur_req = "R2";
    src_en = '0; glb_en = 1; src_lvl = '0;
    step('1, 1, 0); step('1, 1, 0);
    chk("R2", {accept, svc_lo, svc_hi}, 0);
    src_en = '1; glb_en = 0;
    step('1, 1, 0); step('1, 1, 0);
    chk("R2", {accept, svc_lo, vec_addr}, 0);
    src_en = 6'b111011; glb_en = 1;
    step(6'b000100, 1, 0); step('0, 0, 0);
    chk("R2", {accept, svc_lo}, 0);

    // R4 and R6: fixed order within low level
    cur_req = "R4";
    src_en = '1;
    step(6'b111110, 1, 0);
    chk("R4", accept, 1); chk("R6", vec_addr, 16'h000B); chk("R7", svc_lo, 1);
    step('0, 0, 1);
    chk("R9", svc_lo, 0); chk("R6", vec_addr, 16'h000B);
    for (int n = 0; n < NS; n++) begin
      step(6'(1 << n), 1, 0);
      chk("R6", vec_addr, 3 + 8 * n);
      step('0, 0, 1);
    end

    // R3: high level beats lower index
    cur_req = "R3";
    src_lvl = 6'b100000;
    step(6'b100001, 1, 0);
    chk("R3", vec_addr, 16'h002B); chk("R3", {svc_hi, svc_lo}, 2'b10);
    step('0, 0, 1);

    // R5: no acceptance without instruction boundary
    cur_req = "R5";
    step(6'b000001, 0, 0); step(6'b000001, 0, 0); step(6'b000001, 0, 0);
    chk("R5", {accept, svc_lo}, 0);
    step(6'b000001, 1, 0);
    chk("R5", accept, 1);

    // R7 / R8: same level blocked, high preempts low, high blocks all
    cur_req = "R7";
    step(6'b000010, 1, 0); step(6'b000010, 1, 0);
    chk("R7", accept, 0);
    cur_req = "R8";
    step(6'b100010, 1, 0);
    chk("R8", accept, 1); chk("R8", {svc_hi, svc_lo}, 2'b11);
    step(6'b100011, 1, 0); step(6'b100011, 1, 0);
    chk("R8", accept, 0);

    // R9: return ordering and no take on return edge
    cur_req = "R9";
    step(6'b100011, 1, 1);
    chk("R9", {accept, svc_hi, svc_lo}, 3'b001);
    step('0, 0, 1);
    chk("R9", {svc_hi, svc_lo}, 0);

    // Mixed traffic against the model
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      src_en  = 6'($urandom) | 6'($urandom);
      src_lvl = 6'($urandom);
      glb_en  = ($urandom % 8) != 0;
      step(6'($urandom) & 6'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0);
    end
    step('0, 0, 0);
    finish_run();
  end
endmodule